// File: doc/BRIEF.md
# Super-Slot Speed-Mode Crossbar Sequencer

This block paces an input-queued crossbar that keeps one virtual output queue per input/output pair. Time-slots arrive as ticks and are grouped into super-slots of `S` ticks. On the first tick of each super-slot the block takes a crossbar matching and a speed mode `k` from an external decision unit and holds both for the whole super-slot. The matching is exercised in the first `k` ticks only. The remaining ticks are idle, so a lower mode saves transfer energy at the cost of queueing delay.

Only packet counts are tracked. Arrival pulses raise a queue's backlog. Each transfer cycle strobes the dequeue line of every queue the latched matching selects, provided that queue is not empty. A free-running counter of transfer cycles serves as a power proxy.

Top module: `slot_xbar_seq`

## Requirements
- R1: After reset every backlog count and the transfer counter read 0, and the next tick is the first tick of a super-slot.
- R2: `ss_start_o` is high during exactly the tick that opens a super-slot, which is every `S`-th tick counted from reset. It is low on all other cycles.
- R3: The matching and the mode are sampled only on the opening tick. Values on `cfg_i` and `mode_i` during the other ticks of the super-slot have no effect on the dequeue strobes.
- R4: With latched mode `k`, transfer cycles occur on ticks 0 to `k-1` of the super-slot and none on the remaining `S-k` ticks. A mode value of 0 acts as 1, and a value above `S` acts as `S`.
- R5: `cfg_i[i*IW +: IW]` names the output for input `i`. In a transfer cycle, queue `q = i*N + j` is strobed on `deq_o[q]` when input `i` is matched to output `j` and its count is nonzero. Its count then falls by one after that clock edge. Strobes occur only during ticks.
- R6: A selected queue whose count is 0 gets no strobe and keeps a count of 0.
- R7: Arrivals on `arr_i[q]` are counted on every clock edge, whether or not a tick is present. An arrival together with a dequeue leaves the count unchanged. An arrival at the maximum count `2^CW-1` with no dequeue is dropped.
- R8: If an input names an output already claimed by a lower-numbered input, that input is not served. At most one strobe goes to each output and at most one to each input per cycle.
- R9: `xfer_cnt_o` rises by 1 (modulo `2^PW`) after every transfer cycle, even one in which every selected queue is empty. It is unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_tick_i | input | 1 | One-cycle pulse marking a time-slot |
| arr_i | input | N*N | Per-queue arrival pulse, queue q = i*N+j |
| cfg_i | input | N*IW | Output index chosen for each input |
| mode_i | input | MW | Requested speed mode |
| deq_o | output | N*N | Per-queue dequeue strobe |
| backlog_o | output | N*N*CW | Per-queue backlog count, queue q at bits q*CW |
| ss_start_o | output | 1 | High on the opening tick of a super-slot |
| xfer_cnt_o | output | PW | Wrapping count of transfer cycles |

## Verification
The bench uses N=2, S=4, CW=3 and PW=6. With these values every 2-bit matching word can be swept, including the two conflicting ones, against every 3-bit mode value, including 0 and the values above S. The sweep also drives new matching and mode values in the middle of each super-slot, and these must be ignored. The 3-bit counts reach saturation after a handful of arrivals, and the 6-bit transfer counter wraps within a few dozen super-slots.

// File: rtl/sxs_pkg.sv
package sxs_pkg;
  function automatic int unsigned clamp_mode(input int unsigned m, input int unsigned s);
    if (m == 0) return 1;
    if (m > s) return s;
    return m;
  endfunction
endpackage

// File: rtl/sxs_slot_ctl.sv
module sxs_slot_ctl #(
  parameter int N  = 2,
  parameter int S  = 4,
  parameter int IW = 1,
  parameter int MW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [N*IW-1:0] cfg_i,
  input  logic [MW-1:0]   mode_i,
  output logic [N*IW-1:0] cfg_o,
  output logic            active_o,
  output logic            start_o
);
  import sxs_pkg::*;
  localparam int SW = (S > 1) ? $clog2(S) : 1;

  logic [SW-1:0]   slot_q;
  logic [N*IW-1:0] cfg_q;
  logic [MW-1:0]   mode_q, mode_c, mode_eff;
  logic            at_first;

  always_comb begin
    at_first = (slot_q == '0);
    mode_c   = MW'(clamp_mode(32'(mode_i), S));
    mode_eff = at_first ? mode_c : mode_q;
    cfg_o    = at_first ? cfg_i : cfg_q;
    active_o = tick_i && (32'(slot_q) < 32'(mode_eff));
    start_o  = tick_i && at_first;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      cfg_q  <= '0;
      mode_q <= MW'(1);
    end else if (tick_i) begin
      if (32'(slot_q) == S - 1) slot_q <= '0;
      else                      slot_q <= slot_q + 1'b1;
      if (at_first) begin
        cfg_q  <= cfg_i;
        mode_q <= mode_c;
      end
    end
  end

  assert_hold_cfg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !at_first) |=> ($stable(cfg_q) && $stable(mode_q)));

  assert_first_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> active_o);

  assert_mode_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(mode_q) >= 1) && (32'(mode_q) <= S));

  if (S > 1) begin : g_period
    assert_start_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |=> !at_first);
  end
endmodule

// File: rtl/sxs_match.sv
module sxs_match #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N*IW-1:0] cfg_i,
  output logic [N*N-1:0]  sel_o
);
  logic [N-1:0] claimed;

  always_comb begin
    claimed = '0;
    sel_o   = '0;
    for (int i = 0; i < N; i++) begin
      int jj;
      jj = int'(cfg_i[i*IW +: IW]);
      if (jj < N) begin
        if (!claimed[jj]) begin
          claimed[jj]     = 1'b1;
          sel_o[i*N + jj] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sxs_voq_cnt.sv
module sxs_voq_cnt #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arr_i,
  input  logic          req_i,
  output logic          deq_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  assign deq_o = req_i && (cnt_q != '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({arr_i, deq_o})
        2'b10:   if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_empty_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !arr_i) |=> (cnt_q == '0));

  assert_arr_deq_same_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_i && deq_o) |=> $stable(cnt_q));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1 && arr_i && !req_i) |=> (cnt_q == '1));
endmodule

// File: rtl/slot_xbar_seq.sv
module slot_xbar_seq #(
  parameter int N  = 2,
  parameter int S  = 4,
  parameter int CW = 4,
  parameter int PW = 16,
  localparam int NQ = N * N,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int MW = $clog2(S + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_tick_i,
  input  logic [NQ-1:0]    arr_i,
  input  logic [N*IW-1:0]  cfg_i,
  input  logic [MW-1:0]    mode_i,
  output logic [NQ-1:0]    deq_o,
  output logic [NQ*CW-1:0] backlog_o,
  output logic             ss_start_o,
  output logic [PW-1:0]    xfer_cnt_o
);
  logic [N*IW-1:0] cfg_eff;
  logic            active;
  logic [NQ-1:0]   sel;

  sxs_slot_ctl #(.N(N), .S(S), .IW(IW), .MW(MW)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(slot_tick_i),
    .cfg_i(cfg_i), .mode_i(mode_i),
    .cfg_o(cfg_eff), .active_o(active), .start_o(ss_start_o)
  );

  sxs_match #(.N(N), .IW(IW)) u_match (.cfg_i(cfg_eff), .sel_o(sel));

  for (genvar q = 0; q < NQ; q++) begin : g_voq
    sxs_voq_cnt #(.CW(CW)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .arr_i(arr_i[q]),
      .req_i(sel[q] && active), .deq_o(deq_o[q]),
      .cnt_o(backlog_o[q*CW +: CW])
    );
  end

  logic [PW-1:0] xfer_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     xfer_q <= '0;
    else if (active) xfer_q <= xfer_q + 1'b1;
  end
  assign xfer_cnt_o = xfer_q;

  assert_xfer_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |=> (xfer_cnt_o == $past(xfer_cnt_o) + 1'b1));

  assert_xfer_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> $stable(xfer_cnt_o));

  assert_deq_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_o != '0) |-> slot_tick_i);

  for (genvar k = 0; k < N; k++) begin : g_excl
    logic [N-1:0] col, row;
    always_comb begin
      for (int m = 0; m < N; m++) begin
        col[m] = deq_o[m*N + k];
        row[m] = deq_o[k*N + m];
      end
    end
    assert_one_per_output_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col));
    assert_one_per_input_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(row));
  end
endmodule

// File: tb/sim_slot_xbar_seq.sv
module sim_slot_xbar_seq;
  localparam int CLK_P = 10;
  localparam int N = 2, S = 4, CW = 3, PW = 6;
  localparam int NQ = 4;

  logic clk = 0, rst_ni = 0, slot_tick = 0;
  logic [3:0] arr = '0;
  logic [1:0] cfg = '0;
  logic [2:0] mode = '0;
  logic [3:0] deq;
  logic [NQ*CW-1:0] backlog;
  logic ss_start;
  logic [PW-1:0] xfer;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_cnt[NQ];
  int m_slot, m_mode, m_x;
  logic [1:0] m_cfg;

  always #(CLK_P/2) clk = ~clk;

  slot_xbar_seq #(.N(N), .S(S), .CW(CW), .PW(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .slot_tick_i(slot_tick), .arr_i(arr),
    .cfg_i(cfg), .mode_i(mode), .deq_o(deq), .backlog_o(backlog),
    .ss_start_o(ss_start), .xfer_cnt_o(xfer)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    for (int q = 0; q < NQ; q++)
      chk(int'(backlog[q*CW +: CW]) == m_cnt[q], tag, $sformatf("backlog[%0d]", q),
          int'(backlog[q*CW +: CW]), m_cnt[q]);
    chk(int'(xfer) == m_x, "R9", "xfer_cnt", int'(xfer), m_x);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; slot_tick = 0; arr = '0;
    #2;
    for (int q = 0; q < NQ; q++) m_cnt[q] = 0;
    m_slot = 0; m_mode = 1; m_x = 0; m_cfg = '0;
    @(negedge clk);
    rst_ni = 1;
    #1;
    check_state("R1");
  endtask

  task automatic step(input bit tk, input logic [3:0] a, input logic [1:0] c,
                      input int md, input string tag);
    bit first, act;
    int km, em;
    logic [1:0] ec;
    logic [3:0] s, ed;
    @(negedge clk);
    slot_tick = tk; arr = a; cfg = c; mode = 3'(md);
    #1;
    first = (m_slot == 0);
    km = (md == 0) ? 1 : (md > S) ? S : md;
    em = first ? km : m_mode;
    ec = first ? c : m_cfg;
    act = tk && (m_slot < em);
    s = '0;
    s[0*2 + ec[0]] = 1'b1;
    if (ec[1] != ec[0]) s[2 + ec[1]] = 1'b1;
    for (int q = 0; q < NQ; q++) ed[q] = act && s[q] && (m_cnt[q] > 0);
    chk(deq == ed, tag, "deq", int'(deq), int'(ed));
    chk(ss_start == (tk && first), "R2", "ss_start", int'(ss_start), int'(tk && first));
    @(posedge clk);
    for (int q = 0; q < NQ; q++) begin
      if (a[q] && !ed[q]) begin
        if (m_cnt[q] < 7) m_cnt[q]++;
      end else if (!a[q] && ed[q]) m_cnt[q]--;
    end
    if (tk) begin
      if (first) begin m_cfg = c; m_mode = km; end
      m_slot = (m_slot + 1) % S;
      if (act) m_x = (m_x + 1) % 64;
    end
    #1;
    check_state(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    finish_run();
  end

  initial begin
    do_reset();
    // R1: opening tick right after reset
    step(1, 4'b0000, 2'b10, 4, "R1");
    // R6: empty queues, full speed
    for (int t = 0; t < 7; t++) step(1, 4'b0000, 2'b10, 4, "R6");
    // R7: arrivals without ticks, then saturation
    for (int t = 0; t < 10; t++) step(0, 4'b1111, 2'b01, 2, "R7");
    // R5: straight matching then crossed, full speed
    for (int t = 0; t < 4; t++) step(1, 4'b0000, 2'b10, 4, "R5");
    for (int t = 0; t < 4; t++) step(1, 4'b0000, 2'b01, 4, "R5");
    // R7: arrival together with dequeue
    for (int t = 0; t < 4; t++) step(1, 4'b1111, 2'b10, 4, "R7");
    // R8: conflicting matchings
    for (int t = 0; t < 4; t++) step(1, 4'b0000, 2'b00, 4, "R8");
    for (int t = 0; t < 4; t++) step(1, 4'b0000, 2'b11, 3, "R8");
    do_reset();
    // R4/R3: sweep all matchings and mode values, disturb inputs mid super-slot
    for (int c = 0; c < 4; c++)
      for (int md = 0; md < 8; md++)
        for (int sl = 0; sl < S; sl++) begin
          logic [3:0] a;
          a = 4'((c * 3 + md * 5 + sl * 7) % 16);
          if (sl == 0) step(1, a, 2'(c), md, "R4");
          else step(1, a, 2'(c) ^ 2'(sl), (md + sl) % 8, "R3");
          if (sl == 1) step(0, 4'b0110, 2'(c + 1), 7 - md, "R7");
        end
    // R9: empty queues still count cycles; wrap the 6-bit counter
    do_reset();
    for (int t = 0; t < 80; t++) step(1, 4'b0000, 2'(t % 4), 4, "R9");
    // R1: reset mid-run
    step(1, 4'b1111, 2'b10, 2, "R1");
    do_reset();
    step(1, 4'b0000, 2'b10, 4, "R1");
    finish_run();
  end
endmodule